// File: doc/BRIEF.md
# PCI host bridge register interface

This block is the CPU-side register file of a PCI host bridge. A CPU reaches it over a simple 32-bit bus: it asserts a select with address, direction and write data, and holds them until the block answers with a one-cycle ready. The window holds the bridge's own 256-byte configuration header, a configuration-address register, a memory-base register and an I/O-base register. A data-port offset turns every CPU access into one 4-byte configuration transaction on a request/acknowledge port toward the PCI side. The transaction is aimed at the address held in the configuration-address register.

The I/O-base register places a 256 KiB I/O window in CPU space. A combinational output tells the address decoder whether a CPU address falls inside that window. The window moves only when a write changes its base bits. Four level-sensitive device interrupts are routed to four interrupt outputs. Each device is placed by its device number, which is its device/function value shifted right by three.

Top module: `pcib_regs`

## Requirements
- R1: Offsets 0x000 to 0x0FC (bits 1:0 of the address ignored) read and write the 64 words of the bridge's configuration header, and a written word reads back unchanged.
- R2: After reset, header word 0x004 reads 0x02900080. This is command bit 7, the wait-cycle control, and status bits 4 (capabilities list), 7 (fast back-to-back capable) and 10:9 = 01 (medium select timing). The other header words read zero, cpu_ready and cfg_req are low, and irq_out is zero.
- R3: Offset 0x1C0 is the configuration-address register. It resets to zero, and all 32 bits are readable and writable.
- R4: Offset 0x1C4 is the memory-base register. It resets to zero, and a write stores the written value ANDed with 0xFF000001.
- R5: Offset 0x1C8 is the I/O-base register and resets to 0xFE240000. A write whose bits 31:18 differ from the register's bits 31:18 stores the written value ANDed with 0xFFFC0001.
- R6: A write to 0x1C8 whose bits 31:18 equal the register's bits 31:18 leaves the whole register unchanged, bit 0 included.
- R7: io_hit is high, in the same cycle, exactly when io_probe_addr (CPU address bits 31:18) equals bits 31:18 of the I/O-base register.
- R8: A write to offset 0x220 issues one configuration transaction with cfg_we = 1, cfg_addr equal to the configuration-address register and cfg_wdata equal to the written data. A read of 0x220 issues one with cfg_we = 0.
- R9: cfg_req rises on the clock edge that accepts a data-port access. It stays high with cfg_we, cfg_addr and cfg_wdata stable until the clock edge that samples cfg_ack high, and falls on that edge. For a read, the cfg_rdata sampled on that edge is returned on cpu_rdata.
- R10: cpu_ready is a one-cycle pulse. It comes one clock after a register access is accepted. For a data-port access it comes one clock after cfg_ack is sampled, so an acknowledge given L cycles after the request becomes visible yields ready L+2 cycles after the access starts. cfg_req and cpu_ready are never high together.
- R11: Reads of any offset other than those above return zero, and writes to them change no register and no header word.
- R12: Device i has device/function value DEVFN_MAP[8i+7:8i] and device number d = value >> 3. Output irq_out[d mod 4] is the OR of the irq_in bits of the devices mapped to it, registered with one cycle of delay. The defaults are 0x18, 0x00, 0x10 and 0x08 for devices 0 to 3, which send device 0 to output 3, device 1 to output 0, device 2 to output 2 and device 3 to output 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte offset within the register window |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Read data, valid while cpu_ready is high on a read |
| cpu_ready | output | 1 | One-cycle access completion |
| cfg_req | output | 1 | Configuration transaction request |
| cfg_we | output | 1 | Configuration transaction direction |
| cfg_addr | output | 32 | Configuration address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Configuration transaction done |
| cfg_rdata | input | 32 | Configuration read data, sampled with cfg_ack |
| io_probe_addr | input | 14 | CPU address bits 31:18 to test against the I/O window |
| io_hit | output | 1 | Address falls inside the I/O window |
| irq_in | input | NUM_IRQ | Device interrupt levels |
| irq_out | output | NUM_IRQ | Routed interrupt levels |

## Verification
On every cycle the assertions check the handshake shape: ready is a single-cycle pulse and never overlaps a pending request, the request is held with stable fields until it is acknowledged, and no new transaction starts while one is pending. They also check that a same-base I/O-base write leaves the register untouched and that a routed interrupt output is only ever driven by some active input. The bench's scenarios show the values themselves: reset contents, the write masks, the window moving and the hit decode around its edges, and the transaction contents and ready latency against acknowledge delays. They also show the data returned from the PCI side, the silence of unmapped offsets, and the specific device-to-output routing.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [15:0] OFS_CFG_ADDR = 16'h01C0;
  localparam logic [15:0] OFS_MEM_BASE = 16'h01C4;
  localparam logic [15:0] OFS_IO_BASE  = 16'h01C8;
  localparam logic [15:0] OFS_CFG_DATA = 16'h0220;

  localparam logic [31:0] MEM_BASE_KEEP    = 32'hFF00_0001;
  localparam logic [31:0] IO_BASE_KEEP     = 32'hFFFC_0001;
  localparam logic [31:0] IO_BASE_INIT     = 32'hFE24_0000;
  localparam logic [31:0] HDR_CMDSTAT_INIT = 32'h0290_0080;
  localparam int unsigned HDR_CMDSTAT_IDX  = 1;

  typedef enum logic [2:0] {
    SEL_HDR,
    SEL_CFG_ADDR,
    SEL_MEM_BASE,
    SEL_IO_BASE,
    SEL_CFG_DATA,
    SEL_NONE
  } reg_sel_e;

  typedef enum logic {
    CP_IDLE,
    CP_WAIT
  } cp_state_e;

  function automatic reg_sel_e decode_offset(input logic [15:0] a,
                                             input int unsigned hdr_bytes);
    logic [15:0] w;
    w = a & 16'hFFFC;
    if (32'(w) < hdr_bytes) return SEL_HDR;
    case (w)
      OFS_CFG_ADDR: return SEL_CFG_ADDR;
      OFS_MEM_BASE: return SEL_MEM_BASE;
      OFS_IO_BASE:  return SEL_IO_BASE;
      OFS_CFG_DATA: return SEL_CFG_DATA;
      default:      return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pcib_hdr.sv
module pcib_hdr
  import pcib_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);

  function automatic logic [DW-1:0] init_word(input int unsigned i);
    if (i == HDR_CMDSTAT_IDX) return DW'(HDR_CMDSTAT_INIT);
    return '0;
  endfunction

  logic [DW-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [DW-1:0] RST_VAL = init_word(g);
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[g] <= RST_VAL;
      end else if (we && (widx == IDX_W'(g))) begin
        mem[g] <= wdata;
      end
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/pcib_iowin.sv
module pcib_iowin
  import pcib_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic [31:18] probe,
  output logic [31:0] base,
  output logic        hit
);

  logic [31:0] base_q;
  logic        relocate;

  assign relocate = wr && (wdata[31:18] != base_q[31:18]);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= IO_BASE_INIT;
    end else if (relocate) begin
      base_q <= wdata & IO_BASE_KEEP;
    end
  end

  assign base = base_q;
  assign hit  = (probe == base_q[31:18]);

  // R6: a write that keeps the base bits leaves every bit alone
  a_r6_same_base_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr && (wdata[31:18] == base_q[31:18])) |=> $stable(base_q));

endmodule

// File: rtl/pcib_cfg_port.sv
module pcib_cfg_port
  import pcib_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] done_rdata,
  output logic          cfg_req,
  output logic          cfg_we,
  output logic [AW-1:0] cfg_addr,
  output logic [DW-1:0] cfg_wdata,
  input  logic          cfg_ack,
  input  logic [DW-1:0] cfg_rdata
);

  cp_state_e     state_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CP_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        CP_IDLE: begin
          if (start) begin
            state_q <= CP_WAIT;
            we_q    <= start_we;
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
          end
        end
        CP_WAIT: begin
          if (cfg_ack) state_q <= CP_IDLE;
        end
        default: state_q <= CP_IDLE;
      endcase
    end
  end

  assign busy       = (state_q == CP_WAIT);
  assign done       = busy && cfg_ack;
  assign done_rdata = we_q ? '0 : cfg_rdata;
  assign cfg_req    = busy;
  assign cfg_we     = we_q;
  assign cfg_addr   = addr_q;
  assign cfg_wdata  = wdata_q;

  // R9: a pending request keeps its fields until acknowledged
  a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_we) &&
                               $stable(cfg_addr) && $stable(cfg_wdata)));

  // R8: one transaction per access, never a start on top of a pending one
  a_r8_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

endmodule

// File: rtl/pcib_irq_route.sv
module pcib_irq_route #(
  parameter int unsigned            NUM_IRQ   = 4,
  parameter logic [NUM_IRQ*8-1:0]   DEVFN_MAP = {8'h08, 8'h10, 8'h00, 8'h18}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] irq_out
);

  function automatic logic [NUM_IRQ-1:0] src_mask(input int unsigned k);
    logic [NUM_IRQ-1:0] m;
    int unsigned        dev;
    m = '0;
    for (int unsigned i = 0; i < NUM_IRQ; i++) begin
      dev = 32'(DEVFN_MAP[i*8 +: 8]) >> 3;
      if ((dev % NUM_IRQ) == k) m[i] = 1'b1;
    end
    return m;
  endfunction

  logic [NUM_IRQ-1:0] routed;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_out
    localparam logic [NUM_IRQ-1:0] MASK = src_mask(k);
    assign routed[k] = |(irq_in & MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= routed;
  end

  // R12: all inputs quiet means all outputs quiet one cycle later
  a_r12_quiet: assert property (@(posedge clk) disable iff (rst)
    (irq_in == '0) |=> (irq_out == '0));

  // R12: an output is only ever raised by some input one cycle earlier
  a_r12_has_source: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> ($past(irq_in) != '0));

endmodule

// File: rtl/pcib_regs.sv
module pcib_regs
  import pcib_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 10,
  parameter int unsigned          HDR_WORDS = 64,
  parameter int unsigned          NUM_IRQ   = 4,
  parameter logic [NUM_IRQ*8-1:0] DEVFN_MAP = {8'h08, 8'h10, 8'h00, 8'h18}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_sel,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [31:0]        cpu_wdata,
  output logic [31:0]        cpu_rdata,
  output logic               cpu_ready,
  output logic               cfg_req,
  output logic               cfg_we,
  output logic [31:0]        cfg_addr,
  output logic [31:0]        cfg_wdata,
  input  logic               cfg_ack,
  input  logic [31:0]        cfg_rdata,
  input  logic [31:18]       io_probe_addr,
  output logic               io_hit,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] irq_out
);

  localparam int unsigned DW        = WORD_W;
  localparam int unsigned HDR_IDX_W = $clog2(HDR_WORDS);
  localparam int unsigned HDR_BYTES = HDR_WORDS * 4;

  reg_sel_e  sel;
  logic      cp_busy;
  logic      cp_done;
  logic [DW-1:0] cp_rdata;
  logic      accept;
  logic      wr_acc;

  logic [DW-1:0] cfg_addr_q;
  logic [DW-1:0] mem_base_q;
  logic [DW-1:0] io_base;
  logic [DW-1:0] hdr_rdata;
  logic [DW-1:0] rd_mux;
  logic [HDR_IDX_W-1:0] hdr_idx;

  assign sel     = decode_offset(16'(cpu_addr), HDR_BYTES);
  assign accept  = cpu_sel && !cpu_ready && !cp_busy;
  assign wr_acc  = accept && cpu_we;
  assign hdr_idx = cpu_addr[HDR_IDX_W+1:2];

  pcib_hdr #(
    .WORDS (HDR_WORDS),
    .DW    (DW)
  ) i_hdr (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_acc && (sel == SEL_HDR)),
    .widx  (hdr_idx),
    .wdata (cpu_wdata),
    .ridx  (hdr_idx),
    .rdata (hdr_rdata)
  );

  pcib_iowin i_iowin (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_acc && (sel == SEL_IO_BASE)),
    .wdata (cpu_wdata),
    .probe (io_probe_addr),
    .base  (io_base),
    .hit   (io_hit)
  );

  pcib_cfg_port #(
    .AW (DW),
    .DW (DW)
  ) i_cfg_port (
    .clk         (clk),
    .rst         (rst),
    .start       (accept && (sel == SEL_CFG_DATA)),
    .start_we    (cpu_we),
    .start_addr  (cfg_addr_q),
    .start_wdata (cpu_wdata),
    .busy        (cp_busy),
    .done        (cp_done),
    .done_rdata  (cp_rdata),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_ack     (cfg_ack),
    .cfg_rdata   (cfg_rdata)
  );

  pcib_irq_route #(
    .NUM_IRQ   (NUM_IRQ),
    .DEVFN_MAP (DEVFN_MAP)
  ) i_irq (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .irq_out (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_addr_q <= '0;
      mem_base_q <= '0;
    end else if (wr_acc) begin
      if (sel == SEL_CFG_ADDR) cfg_addr_q <= cpu_wdata;
      if (sel == SEL_MEM_BASE) mem_base_q <= cpu_wdata & MEM_BASE_KEEP;
    end
  end

  always_comb begin
    case (sel)
      SEL_HDR:      rd_mux = hdr_rdata;
      SEL_CFG_ADDR: rd_mux = cfg_addr_q;
      SEL_MEM_BASE: rd_mux = mem_base_q;
      SEL_IO_BASE:  rd_mux = io_base;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      if (cp_done) begin
        cpu_ready <= 1'b1;
        cpu_rdata <= cp_rdata;
      end else if (accept && (sel != SEL_CFG_DATA)) begin
        cpu_ready <= 1'b1;
        cpu_rdata <= cpu_we ? '0 : rd_mux;
      end
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R10: the CPU is never released while a transaction is still pending
  a_r10_no_ready_while_req: assert property (@(posedge clk) disable iff (rst)
    !(cfg_req && cpu_ready));

endmodule

// File: tb/test_pcib_regs.sv
module test_pcib_regs;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_sel, cpu_we;
  logic [9:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_ready;
  logic        cfg_req, cfg_we, cfg_ack;
  logic [31:0] cfg_addr, cfg_wdata, cfg_rdata;
  logic [31:18] io_probe_addr;
  logic        io_hit;
  logic [3:0]  irq_in, irq_out;

  always #2 clk = ~clk;

  pcib_regs i_pcib_regs (
    .clk (clk), .rst (rst),
    .cpu_sel (cpu_sel), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
    .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata), .cpu_ready (cpu_ready),
    .cfg_req (cfg_req), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
    .cfg_wdata (cfg_wdata), .cfg_ack (cfg_ack), .cfg_rdata (cfg_rdata),
    .io_probe_addr (io_probe_addr), .io_hit (io_hit),
    .irq_in (irq_in), .irq_out (irq_out)
  );

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
  } exp_t;

  exp_t        exp_q[$];
  exp_t        cur;
  int          total = 0;
  int          bad   = 0;
  bit          finished = 0;
  int          ack_lat = 0;
  logic [31:0] resp_data = '0;

  task automatic check32(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit we, input logic [9:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 200);
    rd = cpu_rdata;
    cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] rd;
    int          cyc;
    bus(1'b1, a, d, rd, cyc);
  endtask

  task automatic rd_check(input string tag, input logic [9:0] a,
                          input logic [31:0] exp);
    logic [31:0] rd;
    int          cyc;
    bus(1'b0, a, 32'h0, rd, cyc);
    check32(tag, rd, exp);
  endtask

  // Driver for the data port: pushes the expected transaction first
  task automatic dp_access(input bit we, input logic [31:0] car,
                           input logic [31:0] d, input int lat,
                           input logic [31:0] resp, output logic [31:0] rd,
                           output int cyc);
    exp_t e;
    e.we = we; e.addr = car; e.data = d;
    exp_q.push_back(e);
    ack_lat   = lat;
    resp_data = resp;
    bus(we, 10'h220, d, rd, cyc);
  endtask

  // Monitor and responder on the configuration port
  initial begin
    cfg_ack = 1'b0;
    cfg_rdata = '0;
    forever begin
      @(negedge clk);
      if (cfg_req) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R8 unexpected transaction actual=%h expected=none", cfg_addr);
        end else begin
          cur = exp_q.pop_front();
          check32("R8 cfg_we", {31'b0, cfg_we}, {31'b0, cur.we});
          check32("R8 cfg_addr", cfg_addr, cur.addr);
          if (cur.we) check32("R8 cfg_wdata", cfg_wdata, cur.data);
        end
        repeat (ack_lat) @(negedge clk);
        cfg_ack = 1'b1;
        cfg_rdata = resp_data;
        @(negedge clk);
        cfg_ack = 1'b0;
        cfg_rdata = '0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [3:0] route(input logic [3:0] i);
    // device0->3, device1->0, device2->2, device3->1
    return {i[0], i[2], i[3], i[1]};
  endfunction

  initial begin
    logic [31:0] rd;
    int          cyc;
    rst = 1'b1; cpu_sel = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    io_probe_addr = '0; irq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    check32("R2 ready", {31'b0, cpu_ready}, 32'h0);
    check32("R2 cfg_req", {31'b0, cfg_req}, 32'h0);
    check32("R2 irq_out", {28'b0, irq_out}, 32'h0);
    rd_check("R2 cmd/status", 10'h004, 32'h0290_0080);
    rd_check("R2 header word 0", 10'h000, 32'h0);
    rd_check("R2 header word 0xFC", 10'h0FC, 32'h0);
    rd_check("R3 reset", 10'h1C0, 32'h0);
    rd_check("R4 reset", 10'h1C4, 32'h0);
    rd_check("R5 reset", 10'h1C8, 32'hFE24_0000);

    // R10 register access latency
    bus(1'b0, 10'h1C8, 32'h0, rd, cyc);
    check32("R10 register ready latency", cyc, 1);

    // R1 header words
    wr(10'h000, 32'h1234_5678);
    wr(10'h0FC, 32'hA5A5_5A5A);
    wr(10'h042, 32'hDEAD_BEEF);
    wr(10'h004, 32'h0000_0006);
    rd_check("R1 word 0", 10'h000, 32'h1234_5678);
    rd_check("R1 word 0xFC", 10'h0FC, 32'hA5A5_5A5A);
    rd_check("R1 word 0x40", 10'h040, 32'hDEAD_BEEF);
    rd_check("R1 word 4 overwrite", 10'h004, 32'h0000_0006);

    // R3 / R4
    wr(10'h1C0, 32'hFFFF_FFFF);
    rd_check("R3 all ones", 10'h1C0, 32'hFFFF_FFFF);
    wr(10'h1C4, 32'hFFFF_FFFF);
    rd_check("R4 mask ones", 10'h1C4, 32'hFF00_0001);
    wr(10'h1C4, 32'h1234_5678);
    rd_check("R4 mask pattern", 10'h1C4, 32'h1200_0000);

    // R7 around the reset window
    @(negedge clk);
    io_probe_addr = 14'(32'hFE27_FFFC >> 18); #1;
    check32("R7 hit top of window", {31'b0, io_hit}, 32'h1);
    io_probe_addr = 14'(32'hFE28_0000 >> 18); #1;
    check32("R7 miss above", {31'b0, io_hit}, 32'h0);
    io_probe_addr = 14'(32'hFE23_FFFC >> 18); #1;
    check32("R7 miss below", {31'b0, io_hit}, 32'h0);

    // R5 relocation
    wr(10'h1C8, 32'h1007_FFFF);
    rd_check("R5 relocated", 10'h1C8, 32'h1004_0001);
    @(negedge clk);
    io_probe_addr = 14'(32'h1006_0000 >> 18); #1;
    check32("R7 hit new window", {31'b0, io_hit}, 32'h1);
    io_probe_addr = 14'(32'hFE24_0000 >> 18); #1;
    check32("R7 old window gone", {31'b0, io_hit}, 32'h0);

    // R6 same base ignored, bit 0 included
    wr(10'h1C8, 32'h1005_0000);
    rd_check("R6 same base ignored", 10'h1C8, 32'h1004_0001);
    wr(10'h1C8, 32'h2000_0000);
    rd_check("R5 bit0 cleared on move", 10'h1C8, 32'h2000_0000);
    wr(10'h1C8, 32'h2003_FFFF);
    rd_check("R6 bit0 not set", 10'h1C8, 32'h2000_0000);

    // R11 unmapped offsets
    wr(10'h100, 32'h1111_1111);
    wr(10'h1CC, 32'h2222_2222);
    wr(10'h224, 32'h3333_3333);
    wr(10'h3FC, 32'h4444_4444);
    rd_check("R11 read 0x100", 10'h100, 32'h0);
    rd_check("R11 read 0x224", 10'h224, 32'h0);
    rd_check("R11 read 0x3FC", 10'h3FC, 32'h0);
    rd_check("R11 car untouched", 10'h1C0, 32'hFFFF_FFFF);
    rd_check("R11 mbr untouched", 10'h1C4, 32'h1200_0000);
    rd_check("R11 iobr untouched", 10'h1C8, 32'h2000_0000);
    rd_check("R11 header untouched", 10'h000, 32'h1234_5678);
    check32("R11 no transaction", {31'b0, cfg_req}, 32'h0);

    // R8 / R9 / R10 data port
    wr(10'h1C0, 32'h8000_0810);
    dp_access(1'b1, 32'h8000_0810, 32'hCAFE_F00D, 0, 32'h0, rd, cyc);
    check32("R10 write latency ack 0", cyc, 2);
    dp_access(1'b0, 32'h8000_0810, 32'h0, 3, 32'h1234_ABCD, rd, cyc);
    check32("R9 read data", rd, 32'h1234_ABCD);
    check32("R10 read latency ack 3", cyc, 5);
    wr(10'h1C0, 32'h8000_1800);
    dp_access(1'b0, 32'h8000_1800, 32'h0, 1, 32'h0BAD_F00D, rd, cyc);
    check32("R9 read data second address", rd, 32'h0BAD_F00D);
    check32("R10 read latency ack 1", cyc, 3);
    dp_access(1'b1, 32'h8000_1800, 32'h5555_AAAA, 6, 32'hFFFF_FFFF, rd, cyc);
    check32("R10 write latency ack 6", cyc, 8);
    rd_check("R3 car kept after data port", 10'h1C0, 32'h8000_1800);

    // R12 interrupt routing
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      irq_in = 4'(p);
      @(negedge clk);
      check32($sformatf("R12 route pattern %0d", p), {28'b0, irq_out},
              {28'b0, route(4'(p))});
    end
    @(negedge clk);
    irq_in = 4'b0010;
    #1;
    check32("R12 one cycle delay", {28'b0, irq_out}, {28'b0, route(4'b1111)});
    @(negedge clk);
    check32("R12 after delay", {28'b0, irq_out}, 32'h1);
    irq_in = '0;

    repeat (10) @(negedge clk);
    check32("R8 all transactions seen", exp_q.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule